// File: doc/BRIEF.md
# Low-power autoreload timer with preload

This block is a 16-bit up-counter that runs in single-shot periods. It is driven by a power-of-two prescaler and set up through a small register bank on a simple select/write/read bus. A start command runs the counter from zero up to the active reload value. On the tick where the counter equals that value, the block raises a match flag, returns the counter to zero and stops. A level interrupt follows the match flag while its enable bit is set.

The reload value can be written in two modes:
- **Immediate:** the new value is applied one counter tick after the write.
- **Preload:** the new value is held in a shadow register and applied only at the end of the current period.

In both modes a write-done flag reports when the transfer has happened. Setting the enable bit does not start the timer at once: it becomes active after two counter ticks. A start written during that wait is remembered. An optional clear-on-read mode zeroes the counter whenever software reads it.

The sequencer has four states:
- **IDLE:** the timer is disabled, and the counter and prescaler are held at zero.
- **ARM:** the enable bit is set and the block waits for two ticks.
- **READY:** the timer is enabled and waiting for a start.
- **RUN:** a period is being counted.

The transitions are:
- IDLE→ARM when the enable bit is written to 1.
- ARM→READY on the second tick.
- ARM→RUN on the second tick when a start is pending or arrives in that cycle.
- READY→RUN on an accepted start.
- RUN→READY on the tick that ends the period.
- Any state→IDLE when the enable bit is written to 0.

Register addresses:

| Address | Register | Fields |
|---|---|---|
| 0 | control | bit0 enable, bit1 start, bit2 clear-on-read |
| 1 | config | bits[2:0] divide select, bit3 preload |
| 2 | reload | 16-bit value |
| 3 | count | read-only |
| 4 | status | bit0 match, bit1 write-done; read-only |
| 5 | flag clear | write-only, reads 0 |
| 6 | interrupt enable | bit0 |

Top module: `lpt_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: A divide select n in config bits[2:0] gives one counter tick every 2^n clock cycles. A period with active reload value A lasts A+1 ticks, and the counter reads 0 when the period ends.
- R3: After enable (control bit0) is written to 1 at clock edge E0, a start written at the next edge begins counting at the second tick. The match flag is then set at edge E0 + (A+3)·2^n.
- R4: A start (control bit1, written together with bit0=1) is accepted only while the timer is already enabled. A start written while disabled is ignored, and a start written during RUN neither restarts nor disturbs the count. After the period the counter stays at 0.
- R5: The match flag is status bit0. Writing 1 to flag-clear bit0 clears it. `irq` is high exactly while the match flag and interrupt-enable bit0 are both 1.
- R6: With preload (config bit3) at 0, a reload write becomes the active value on the next counter tick, and the write-done flag (status bit1) is set at that tick. Writing 1 to flag-clear bit1 clears the write-done flag.
- R7: With preload at 1, a reload write leaves the active value unchanged until the running period ends. The written value and the write-done flag take effect at that period-end tick.
- R8: With clear-on-read (control bit2) at 1, a bus read of the count register returns the current value and the counter holds 0 afterwards. With the bit at 0, reads leave the counter running.
- R9: Writes to the config register are ignored while the enable bit is 1 and are accepted while it is 0.
- R10: Writing enable to 0 stops counting at once, zeroes the counter and cancels a start pending from ARM, so a later re-enable does not run.
- R11: Writes to the count and status registers have no effect. The flag-clear register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_rd | input | 1 | Read strobe, qualified by bus_sel; only the count register has a read side effect |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt: match flag AND interrupt enable |

## Verification
The hardest situation to reach is a start that is pending while the timer is still in ARM. It must launch on exactly the second tick, and a disable must cancel it. The stimulus therefore writes enable and start on consecutive edges across every divide select and several reload values, and checks the edge of the match against (A+3)·2^n. It then repeats the pending start at the largest divider, disables mid-arm, re-enables and waits well past the cycle where a leftover start would have matched. The preload case is reached in a similar way: the bench writes a new reload value at the same edge that counting begins and watches that the old value governs the whole period.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int LPT_AW = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_READY = 2'd2,
        ST_RUN   = 2'd3
    } lpt_state_e;

    localparam logic [LPT_AW-1:0] A_CTRL   = 3'd0;
    localparam logic [LPT_AW-1:0] A_CFG    = 3'd1;
    localparam logic [LPT_AW-1:0] A_RELOAD = 3'd2;
    localparam logic [LPT_AW-1:0] A_COUNT  = 3'd3;
    localparam logic [LPT_AW-1:0] A_STAT   = 3'd4;
    localparam logic [LPT_AW-1:0] A_CLR    = 3'd5;
    localparam logic [LPT_AW-1:0] A_IEN    = 3'd6;

    localparam int CTL_EN  = 0;
    localparam int CTL_GO  = 1;
    localparam int CTL_COR = 2;

    localparam int ST_MATCH_BIT = 0;
    localparam int ST_DONE_BIT  = 1;

endpackage

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PW = (1 << SEL_W) - 1;
    localparam logic [PW:0]   SPAN_ONE = 1;
    localparam logic [PW-1:0] P_ONE    = 1;

    logic [PW-1:0] pre_q;
    logic [PW:0]   span;
    logic [PW-1:0] mask;

    // Low n bits all ones marks the last cycle of a 2^n-cycle tick window.
    always_comb begin
        span = (SPAN_ONE << sel) - SPAN_ONE;
        mask = span[PW-1:0];
        tick = run && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + P_ONE;
        end
    end
endmodule

// File: rtl/lpt_seq.sv
module lpt_seq
    import lpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       start_i,
    input  logic       tick_i,
    input  logic       at_end_i,
    output lpt_state_e state_o,
    output logic       period_end_o
);
    lpt_state_e state_q;
    lpt_state_e state_d;
    logic       armed_q;
    logic       pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_ARM;
                ST_ARM:   if (tick_i && armed_q)
                              state_d = (pend_q || start_i) ? ST_RUN : ST_READY;
                ST_READY: if (start_i) state_d = ST_RUN;
                ST_RUN:   if (tick_i && at_end_i) state_d = ST_READY;
            endcase
        end
    end

    // First arming tick seen, and a start captured while arming.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            armed_q <= (state_q == ST_ARM) && (armed_q || tick_i);
            if (state_q != ST_ARM) begin
                pend_q <= 1'b0;
            end else if (start_i) begin
                pend_q <= 1'b1;
            end
        end
    end

    always_comb begin
        state_o      = state_q;
        period_end_o = (state_q == ST_RUN) && tick_i && at_end_i;
    end
endmodule

// File: rtl/lpt_timer.sv
module lpt_timer
    import lpt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [LPT_AW-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int              CFG_HOLD = SEL_W;
    localparam logic [CNT_W-1:0] C_ONE   = 1;

    logic              en_q, cor_q, hold_q, ie_q;
    logic [SEL_W-1:0]  sel_q;
    logic [CNT_W-1:0]  arr_q, arr_sh, cnt_q;
    logic              xfer_q, match_q, done_q;

    logic       wr_ctrl, wr_cfg, wr_rel, wr_clr, wr_ien, rd_cnt;
    logic       en_next, start_acc, run, tick, at_end, period_end, xfer;
    lpt_state_e state;

    always_comb begin
        wr_ctrl   = bus_sel && bus_wr && (bus_addr == A_CTRL);
        wr_cfg    = bus_sel && bus_wr && (bus_addr == A_CFG);
        wr_rel    = bus_sel && bus_wr && (bus_addr == A_RELOAD);
        wr_clr    = bus_sel && bus_wr && (bus_addr == A_CLR);
        wr_ien    = bus_sel && bus_wr && (bus_addr == A_IEN);
        rd_cnt    = bus_sel && bus_rd && (bus_addr == A_COUNT);
        en_next   = wr_ctrl ? bus_wdata[CTL_EN] : en_q;
        start_acc = wr_ctrl && bus_wdata[CTL_GO] && bus_wdata[CTL_EN] && en_q;
        run       = (state != ST_IDLE) && en_next;
        at_end    = (cnt_q == arr_q);
        xfer      = xfer_q && !wr_rel && (hold_q ? period_end : tick);
    end

    lpt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .sel  (sel_q),
        .tick (tick)
    );

    lpt_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_next),
        .start_i     (start_acc),
        .tick_i      (tick),
        .at_end_i    (at_end),
        .state_o     (state),
        .period_end_o(period_end)
    );

    // Control, configuration and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            cor_q  <= 1'b0;
            hold_q <= 1'b0;
            sel_q  <= '0;
            ie_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= bus_wdata[CTL_EN];
                cor_q <= bus_wdata[CTL_COR];
            end
            if (wr_cfg && !en_q) begin
                sel_q  <= bus_wdata[SEL_W-1:0];
                hold_q <= bus_wdata[CFG_HOLD];
            end
            if (wr_ien) ie_q <= bus_wdata[0];
        end
    end

    // Reload shadow and transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_q  <= '0;
            arr_sh <= '0;
            xfer_q <= 1'b0;
        end else begin
            if (wr_rel) begin
                arr_sh <= bus_wdata;
                xfer_q <= 1'b1;
            end else if (xfer) begin
                arr_q  <= arr_sh;
                xfer_q <= 1'b0;
            end
        end
    end

    // Counter and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            match_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (!en_next || (rd_cnt && cor_q)) begin
                cnt_q <= '0;
            end else if (tick && (state == ST_RUN)) begin
                cnt_q <= at_end ? '0 : cnt_q + C_ONE;
            end
            if (period_end) begin
                match_q <= 1'b1;
            end else if (wr_clr && bus_wdata[ST_MATCH_BIT]) begin
                match_q <= 1'b0;
            end
            if (xfer) begin
                done_q <= 1'b1;
            end else if (wr_clr && bus_wdata[ST_DONE_BIT]) begin
                done_q <= 1'b0;
            end
        end
    end

    always_comb begin
        irq = match_q && ie_q;
        unique case (bus_addr)
            A_CTRL:   bus_rdata = CNT_W'({cor_q, 1'b0, en_q});
            A_CFG:    bus_rdata = CNT_W'({hold_q, sel_q});
            A_RELOAD: bus_rdata = arr_q;
            A_COUNT:  bus_rdata = cnt_q;
            A_STAT:   bus_rdata = CNT_W'({done_q, match_q});
            A_IEN:    bus_rdata = CNT_W'(ie_q);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lpt_timer_chk.sv
module lpt_timer_chk
    import lpt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input lpt_state_e       state,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic             match,
    input logic             done,
    input logic             xfer_pend,
    input logic             en,
    input logic [SEL_W:0]   cfg
);
    localparam logic [CNT_W-1:0] K_ONE = 1;

    // R2 R4: while running the counter only holds or steps by one
    a_r4_cnt_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cnt != '0) |-> (cnt == $past(cnt) || cnt == $past(cnt) + K_ONE));

    // R3: leaving ARM needs a counter tick
    a_r3_arm_exit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN || state == ST_READY) && $past(state) == ST_ARM) |-> $past(tick));

    // R5: the match flag only rises out of a running period
    a_r5_match_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match) |-> ($past(state) == ST_RUN));

    // R6 R7: write-done only rises after a pending reload write
    a_r6_done_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(xfer_pend));

    // R9: configuration is frozen while enabled
    a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(cfg));

    // R10: a disabled timer holds a zero count
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cnt == '0));
endmodule

bind lpt_timer lpt_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .tick     (tick),
    .cnt      (cnt_q),
    .match    (match_q),
    .done     (done_q),
    .xfer_pend(xfer_q),
    .en       (en_q),
    .cfg      ({hold_q, sel_q})
);

// File: tb/lpt_timer_test.sv
module lpt_timer_test;
    import lpt_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit ended = 0;

    lpt_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 v = int'(bus_rdata);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output int v);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic wait_match(input int base, output int dt);
        int v;
        dt = -1;
        for (int k = 0; k < 3000; k++) begin
            peek(A_STAT, v);
            if (v[0]) begin
                dt = cyc - base;
                break;
            end
            @(negedge clk);
        end
    endtask

    function automatic int reload_pick(input int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 2;
            default: return 5;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++; n_bad++;
            $display("FAIL R4 watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v, c0, dt, a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 7; i++) begin
            peek(3'(i), v);
            check($sformatf("R1 reg %0d", i), v, 0);
        end
        check("R1 irq", int'(irq), 0);

        // R2 R3: sweep divide select and reload
        for (int s = 0; s < 8; s++) begin
            for (int ai = 0; ai < 4; ai++) begin
                a = reload_pick(ai);
                wr(A_CTRL, 16'h0);
                wr(A_CLR, 16'h3);
                wr(A_CFG, 16'(s));
                wr(A_RELOAD, 16'(a));
                wr(A_CTRL, 16'h1);
                c0 = cyc;
                wr(A_CTRL, 16'h3);
                wait_match(c0, dt);
                check($sformatf("R2 R3 sel=%0d A=%0d match edge", s, a), dt, (a + 3) << s);
                peek(A_STAT, v);
                check("R6 done after arming tick", v[1], 1);
                peek(A_COUNT, v);
                check("R2 count zero at end", v, 0);
                repeat ((2 << s) + 1) @(negedge clk);
                peek(A_COUNT, v);
                check("R4 stays stopped", v, 0);
            end
        end

        // R6 immediate update
        wr(A_CTRL, 16'h0);
        wr(A_CLR, 16'h3);
        wr(A_CFG, 16'h0);
        wr(A_CTRL, 16'h1);
        wr(A_RELOAD, 16'd9);
        peek(A_STAT, v);  check("R6 done not yet", v[1], 0);
        peek(A_RELOAD, v); check("R6 old reload", v, 5);
        @(negedge clk);
        peek(A_STAT, v);  check("R6 done after tick", v[1], 1);
        peek(A_RELOAD, v); check("R6 new reload", v, 9);
        wr(A_CLR, 16'h2);
        peek(A_STAT, v);  check("R6 done cleared", v[1], 0);

        // R7 preload
        wr(A_CTRL, 16'h0);
        wr(A_CFG, 16'h8);
        peek(A_CFG, v);   check("R9 cfg accepted when disabled", v, 8);
        wr(A_CTRL, 16'h1);
        c0 = cyc;
        wr(A_CTRL, 16'h3);
        wr(A_RELOAD, 16'd4);
        repeat (3) @(negedge clk);
        peek(A_RELOAD, v); check("R7 reload held", v, 9);
        peek(A_STAT, v);   check("R7 done held", v[1], 0);
        wait_match(c0, dt);
        check("R7 old value governs period", dt, 12);
        peek(A_STAT, v);   check("R7 done at period end", v[1], 1);
        peek(A_RELOAD, v); check("R7 reload applied", v, 4);
        wr(A_CLR, 16'h1);
        wr(A_CTRL, 16'h3);
        c0 = cyc;
        wait_match(c0, dt);
        check("R7 new period from READY", dt, 5);

        // R5 and R11 flags and irq
        check("R5 irq masked", int'(irq), 0);
        wr(A_STAT, 16'h0);
        peek(A_STAT, v);  check("R11 status write ignored", v[0], 1);
        wr(A_IEN, 16'h1);
        check("R5 irq raised", int'(irq), 1);
        wr(A_CLR, 16'h1);
        check("R5 irq dropped", int'(irq), 0);
        peek(A_STAT, v);  check("R5 match cleared", v[0], 0);
        peek(A_CLR, v);   check("R11 clear reg reads 0", v, 0);

        // R9 locked config
        wr(A_CFG, 16'h5);
        peek(A_CFG, v);   check("R9 cfg locked", v, 8);

        // R8 clear-on-read
        wr(A_CTRL, 16'h0);
        wr(A_CFG, 16'h0);
        peek(A_CFG, v);   check("R9 cfg rewritten", v, 0);
        wr(A_CTRL, 16'h1);
        wr(A_RELOAD, 16'd1000);
        wr(A_CTRL, 16'h7);
        repeat (20) @(negedge clk);
        rd(A_COUNT, v);   check("R8 read value", v, 20);
        peek(A_COUNT, v); check("R8 cleared by read", v, 0);
        @(negedge clk);
        peek(A_COUNT, v); check("R8 counts on", v, 1);
        wr(A_CTRL, 16'h3);
        repeat (5) @(negedge clk);
        rd(A_COUNT, c0);
        rd(A_COUNT, v);
        check("R8 R4 plain read keeps counting", v, c0 + 1);

        // R10 disable mid-run, R11 count write
        wr(A_CTRL, 16'h0);
        peek(A_COUNT, v); check("R10 count zeroed", v, 0);
        wr(A_COUNT, 16'h55);
        repeat (10) @(negedge clk);
        peek(A_COUNT, v); check("R11 count write ignored", v, 0);
        peek(A_STAT, v);  check("R10 no match", v[0], 0);

        // R10 pending start cancelled
        wr(A_CFG, 16'h7);
        wr(A_RELOAD, 16'd2);
        wr(A_CTRL, 16'h1);
        wr(A_CTRL, 16'h3);
        repeat (50) @(negedge clk);
        wr(A_CTRL, 16'h0);
        wr(A_CTRL, 16'h1);
        repeat (1000) @(negedge clk);
        peek(A_STAT, v);  check("R10 pending start cancelled", v[0], 0);
        peek(A_COUNT, v); check("R10 count idle", v, 0);

        // R4 start while disabled
        wr(A_CTRL, 16'h0);
        wr(A_CTRL, 16'h2);
        wr(A_CTRL, 16'h1);
        repeat (1000) @(negedge clk);
        peek(A_STAT, v);  check("R4 disabled start ignored", v[0], 0);
        wr(A_CTRL, 16'h3);
        c0 = cyc;
        wait_match(c0, dt);
        check("R2 R4 start from READY at div 128", int'(dt >= 257 && dt <= 384), 1);

        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule